// File: doc/BRIEF.md
# Stereo Channel Mixer with Ramped Gain

This block sits in an audio datapath between the serial sample receiver and the interpolation filter. Each accepted frame carries one signed left sample and one signed right sample. A 4-bit mixing code chooses, separately for each output channel, whether that channel is silent, carries the right input, carries the left input, or carries the average of both. The chosen sample is then scaled by an 8-bit linear attenuation level and by a soft-mute factor.

Neither gain factor ever jumps. Each applied level walks toward its programmed target one unit at a time, with one step per four frames. A full-scale swing therefore spans roughly a thousand frames, and a new target simply redirects the walk from wherever it stands. The soft-mute factor uses the same walk toward silence or toward full scale, so a mute that is released part-way reverses smoothly. A link bit makes the left target govern both channels. The synchronous reset silences the attenuators; once reset is released they fade up to their targets.

Top module: `chmix_atten`

## Requirements
- R1: The output source for the left channel is chosen by mix_code[3:2] and for the right channel by mix_code[1:0]: 2'b00 gives zero, 2'b01 the right input, 2'b10 the left input, 2'b11 the floor of (left+right)/2 computed on a 25-bit sum. Code 4'b1001 is plain stereo.
- R2: out_valid is high for exactly one cycle, the cycle after each in_valid pulse. out_left and out_right change only on that edge and hold their value otherwise.
- R3: For source sample s, attenuation level a and mute factor m, the output is floor(floor(s*c(a)/256)*c(m)/256), where c(v)=v for v<255 and c(255)=256. Level 255 with factor 255 passes s unchanged, and level 0 gives 0.
- R4: Accepted frames are counted from reset. On every 4th frame, and only then, each applied level and the mute factor move one unit toward their targets. A frame uses the levels as they stood before its own step.
- R5: A target that changes while a ramp is running redirects the ramp from the current level, with no jump.
- R6: While smute is 1 the mute factor walks toward 0. While smute is 0 it walks toward 255. Releasing smute part-way reverses the walk from the current value.
- R7: When link is 1, the right channel's level tracks tgt_left and tgt_right is ignored.
- R8: While rst_n is 0 (sampled on the clock edge), both applied levels become 0, the mute factor becomes 255, the frame count becomes 0, and the outputs and out_valid become 0. After release the levels fade up toward their targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame strobe, one cycle per sample pair |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| mix_code | input | 4 | Source selection for the two output channels |
| tgt_left | input | 8 | Left attenuation target (255 = 0 dB) |
| tgt_right | input | 8 | Right attenuation target |
| link | input | 1 | Use tgt_left for both channels |
| smute | input | 1 | Soft-mute request |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |

## Verification
Some properties are checked on every cycle. Each ramp moves by at most one unit per edge, moves only on a step frame, and always heads toward its target. An output channel whose source is silent, whose level is zero, or whose mute factor is zero comes out as zero. out_valid follows in_valid, and the outputs hold still between frames. The exact sample values can only be shown by the bench's frame-by-frame model: the full fade-in after reset, redirecting a ramp part-way, linked targets, and a soft mute cancelled half-way.

// File: rtl/chmix_pkg.sv
// Shared types for the channel mixer.
package chmix_pkg;
    // Source choice for one output channel; the encoding is decoded by the mixer.
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_AVG   = 2'b11
    } src_e;
endpackage

// File: rtl/chmix_mixer.sv
// Selects the source of one output channel from a left/right pair.
// Assumes two's-complement samples; the average floors via arithmetic shift.
module chmix_mixer #(
    parameter int DW = 24
) (
    input  logic [1:0]           sel,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    output logic signed [DW-1:0] mixed
);
    import chmix_pkg::*;

    logic signed [DW:0] sum;
    logic               unused_lsb;

    // Widened sum so the average never overflows.
    assign sum        = {in_l[DW-1], in_l} + {in_r[DW-1], in_r};
    assign unused_lsb = sum[0];

    // Pick the source named by the selection code.
    always_comb begin
        case (src_e'(sel))
            SRC_RIGHT: mixed = in_r;
            SRC_LEFT:  mixed = in_l;
            SRC_AVG:   mixed = sum[DW:1];
            default:   mixed = '0;
        endcase
    end
endmodule

// File: rtl/chmix_ramp.sv
// Level tracker: moves one unit toward target on each step pulse.
// Assumes the target may change at any time; it holds when equal.
module chmix_ramp #(
    parameter int LW       = 8,
    parameter int INIT_LVL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [LW-1:0] target,
    output logic [LW-1:0] level
);
    // Walk toward target by one unit per step; reset to INIT_LVL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= LW'(INIT_LVL);
        else if (step && level < target)
            level <= level + 1'b1;
        else if (step && level > target)
            level <= level - 1'b1;
    end

    // R4: never moves by more than one unit per edge
    a_r4_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level == $past(level) - 1'b1));

    // R4: without a step pulse the level holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(level));

    // R5: a step below target raises the level
    a_r5_heads_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && level < target) |=> level == $past(level) + 1'b1);

    // R5: a step above target lowers the level
    a_r5_heads_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && level > target) |=> level == $past(level) - 1'b1);
endmodule

// File: rtl/chmix_gain.sv
// Applies attenuation level and mute factor to one sample, truncating twice.
// Assumes full-scale level (all ones) maps to unity gain.
module chmix_gain #(
    parameter int DW = 24,
    parameter int LW = 8
) (
    input  logic signed [DW-1:0] sample,
    input  logic [LW-1:0]        att_lvl,
    input  logic [LW-1:0]        mute_lvl,
    output logic signed [DW-1:0] scaled
);
    localparam int PW = DW + LW + 2;

    logic [LW:0]          c_att, c_mute;
    logic signed [PW-1:0] p1, p2;
    logic signed [DW-1:0] stage1;
    logic                 unused_bits;

    // Map a level to its coefficient; full scale becomes 2^LW.
    function automatic logic [LW:0] coef(input logic [LW-1:0] v);
        return (v == {LW{1'b1}}) ? (LW+1)'(1 << LW) : {1'b0, v};
    endfunction

    assign c_att  = coef(att_lvl);
    assign c_mute = coef(mute_lvl);

    // First multiply by the attenuator, keep floor(p/2^LW).
    assign p1     = {{(LW+2){sample[DW-1]}}, sample} * $signed({{(PW-LW-1){1'b0}}, c_att});
    assign stage1 = p1[DW+LW-1:LW];

    // Second multiply by the mute factor.
    assign p2     = {{(LW+2){stage1[DW-1]}}, stage1} * $signed({{(PW-LW-1){1'b0}}, c_mute});
    assign scaled = p2[DW+LW-1:LW];

    assign unused_bits = ^{p1[PW-1:DW+LW], p1[LW-1:0], p2[PW-1:DW+LW], p2[LW-1:0]};
endmodule

// File: rtl/chmix_atten.sv
// Stereo channel mixer with ramped per-channel attenuation and soft mute.
// Assumes in_valid pulses at most once per frame; one-cycle output latency.
module chmix_atten #(
    parameter int DW          = 24,
    parameter int LW          = 8,
    parameter int STEP_FRAMES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    input  logic [3:0]           mix_code,
    input  logic [LW-1:0]        tgt_left,
    input  logic [LW-1:0]        tgt_right,
    input  logic                 link,
    input  logic                 smute,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right
);
    localparam int          CW    = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_FRAMES - 1);
    localparam int          FULL  = (1 << LW) - 1;
    localparam int          NCH   = 2;

    logic [CW-1:0]        frame_cnt;
    logic                 step;
    logic [LW-1:0]        mute_lvl;
    logic [LW-1:0]        mute_tgt;
    logic [LW-1:0]        tgt   [NCH];
    logic [LW-1:0]        lvl   [NCH];
    logic [1:0]           sel   [NCH];
    logic signed [DW-1:0] mixed [NCH];
    logic signed [DW-1:0] scaled[NCH];

    // Count accepted frames; a step fires on the last frame of each group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (in_valid)
            frame_cnt <= (frame_cnt == LAST) ? '0 : frame_cnt + 1'b1;
    end
    assign step = in_valid && (frame_cnt == LAST);

    assign sel[0]   = mix_code[3:2];
    assign sel[1]   = mix_code[1:0];
    assign tgt[0]   = tgt_left;
    assign tgt[1]   = link ? tgt_left : tgt_right;
    assign mute_tgt = smute ? '0 : LW'(FULL);

    // Soft-mute factor shares the step timing with the attenuators.
    chmix_ramp #(.LW(LW), .INIT_LVL(FULL)) u_mute_ramp (
        .clk(clk), .rst_n(rst_n), .step(step), .target(mute_tgt), .level(mute_lvl)
    );

    // One mixer, attenuator ramp and gain stage per output channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chmix_mixer #(.DW(DW)) u_mixer (
            .sel(sel[ch]), .in_l(in_left), .in_r(in_right), .mixed(mixed[ch])
        );
        chmix_ramp #(.LW(LW), .INIT_LVL(0)) u_att_ramp (
            .clk(clk), .rst_n(rst_n), .step(step), .target(tgt[ch]), .level(lvl[ch])
        );
        chmix_gain #(.DW(DW), .LW(LW)) u_gain (
            .sample(mixed[ch]), .att_lvl(lvl[ch]), .mute_lvl(mute_lvl), .scaled(scaled[ch])
        );
    end

    // Register the processed pair on each accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= scaled[0];
                out_right <= scaled[1];
            end
        end
    end

    // R1: a silent left source yields zero
    a_r1_zero_src_left: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code[3:2] == 2'b00) |=> out_left == '0);

    // R1: a silent right source yields zero
    a_r1_zero_src_right: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code[1:0] == 2'b00) |=> out_right == '0);

    // R2: every accepted frame produces an output strobe next cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: between frames the outputs hold and no strobe appears
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R3: zero attenuation level silences the channel
    a_r3_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lvl[0] == '0) |=> out_left == '0);

    // R6: a fully closed mute factor silences both channels
    a_r6_mute_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_lvl == '0) |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/chmix_atten_bench.sv
module chmix_atten_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [3:0]  mix_code = 4'b1001;
    logic [7:0]  tgt_left = 8'hFF, tgt_right = 8'hFF;
    logic        link = 1'b0, smute = 1'b0;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    int checks = 0, failures = 0;
    bit done = 0;
    int frame_no = 0;

    // Bench model of the ramp state
    int m_al, m_ar, m_mu, m_cnt;

    always #5 clk = ~clk;

    chmix_atten u_chmix_atten (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .mix_code(mix_code),
        .tgt_left(tgt_left), .tgt_right(tgt_right), .link(link), .smute(smute),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic longint coef(int v);
        return (v == 255) ? 256 : v;
    endfunction

    function automatic longint scale(longint s, longint c);
        return (s * c) >>> 8;
    endfunction

    function automatic longint pick(logic [1:0] sel, longint l, longint r);
        case (sel)
            2'b01:   return r;
            2'b10:   return l;
            2'b11:   return (l + r) >>> 1;
            default: return 0;
        endcase
    endfunction

    function automatic int walk(int cur, int tgt);
        if (cur < tgt) return cur + 1;
        if (cur > tgt) return cur - 1;
        return cur;
    endfunction

    function automatic logic [23:0] pat(int n, int salt);
        return 24'((n * 40503 + salt * 7919) ^ 24'h5A5A5A);
    endfunction

    task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_al = 0; m_ar = 0; m_mu = 255; m_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Send one frame, check the registered result against the model, advance the model.
    task automatic send_frame(logic [23:0] l, logic [23:0] r, string req);
        longint sl, sr, el, er;
        @(negedge clk);
        in_left = l; in_right = r; in_valid = 1'b1;
        sl = pick(mix_code[3:2], longint'($signed(l)), longint'($signed(r)));
        sr = pick(mix_code[1:0], longint'($signed(l)), longint'($signed(r)));
        el = scale(scale(sl, coef(m_al)), coef(m_mu));
        er = scale(scale(sr, coef(m_ar)), coef(m_mu));
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_left == 24'(el) && out_right == 24'(er), req,
              {out_left, out_right}, {24'(el), 24'(er)});
        if (m_cnt == 3) begin
            m_al = walk(m_al, int'(tgt_left));
            m_ar = walk(m_ar, link ? int'(tgt_left) : int'(tgt_right));
            m_mu = walk(m_mu, smute ? 0 : 255);
        end
        m_cnt = (m_cnt + 1) % 4;
        frame_no++;
    endtask

    task automatic run_frames(int n, string req);
        for (int i = 0; i < n; i++)
            send_frame(pat(frame_no, 1), pat(frame_no, 2), req);
    endtask

    // R8: reset state, then fade-in from level 0
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R8 reset outputs",
              {out_left, out_right}, 48'h0);
        mix_code = 4'b1001; tgt_left = 8'hFF; tgt_right = 8'hFF;
        send_frame(24'h7FFFFF, 24'h7FFFFF, "R8 first frame silent");
        run_frames(3, "R4 before first step");
        send_frame(24'h400000, 24'h400000, "R4 after first step");
        run_frames(1020, "R8 fade-in");
        send_frame(24'h123456, 24'hE54321, "R3 unity gain");
        check(out_left == 24'h123456 && out_right == 24'hE54321, "R3 unity passthrough",
              {out_left, out_right}, {24'h123456, 24'hE54321});
    endtask

    // R1: every mixing code
    task automatic t_mix();
        for (int c = 0; c < 16; c++) begin
            mix_code = 4'(c);
            send_frame(24'h400000, 24'hC00001, "R1 mix code");
            send_frame(24'h000003, 24'hFFFFFA, "R1 mix odd sum");
        end
        mix_code = 4'b1001;
        send_frame(24'h0ABCDE, 24'hF00000, "R1 stereo code");
        check(out_left == 24'h0ABCDE && out_right == 24'hF00000, "R1 stereo routing",
              {out_left, out_right}, {24'h0ABCDE, 24'hF00000});
    endtask

    // R2: outputs hold and strobe stays low between frames
    task automatic t_valid();
        logic [23:0] hl, hr;
        send_frame(24'h111111, 24'h222222, "R2 frame");
        hl = out_left; hr = out_right;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid && out_left == hl && out_right == hr, "R2 hold",
                  {out_left, out_right}, {hl, hr});
        end
    endtask

    // R5: retarget mid-ramp
    task automatic t_retarget();
        tgt_left = 8'h40;
        run_frames(300, "R5 ramp down");
        tgt_left = 8'hC0;
        run_frames(100, "R5 retargeted ramp");
    endtask

    // R7: linked targets
    task automatic t_link();
        link = 1'b1; tgt_left = 8'h80; tgt_right = 8'hFF;
        run_frames(600, "R7 linked ramp");
        send_frame(24'h3C3C3C, 24'h3C3C3C, "R7 linked frame");
        check(out_left == out_right, "R7 equal channels", {out_left, out_right},
              {out_left, out_left});
        link = 1'b0; tgt_left = 8'hFF; tgt_right = 8'hFF;
        run_frames(600, "R7 unlinked recovery");
    endtask

    // R6: soft mute, cancelled part-way, then full mute
    task automatic t_smute();
        smute = 1'b1;
        run_frames(400, "R6 mute ramp");
        smute = 1'b0;
        run_frames(200, "R6 mute cancelled");
        smute = 1'b1;
        run_frames(1100, "R6 full mute");
        send_frame(24'h7FFFFF, 24'h800000, "R6 muted frame");
        check(out_left == '0 && out_right == '0, "R6 silence", {out_left, out_right}, 48'h0);
        smute = 1'b0;
        run_frames(1030, "R6 unmute");
    endtask

    // R3: zero level gives silence
    task automatic t_zero();
        tgt_left = 8'h00; tgt_right = 8'h00;
        run_frames(1030, "R3 fade to zero");
        send_frame(24'h7FFFFF, 24'h7FFFFF, "R3 zero frame");
        check(out_left == '0 && out_right == '0, "R3 zero level", {out_left, out_right}, 48'h0);
    endtask

    // R8: reset in mid-operation restarts the fade
    task automatic t_rerun();
        tgt_left = 8'hFF; tgt_right = 8'h90;
        run_frames(20, "R8 pre-reset");
        do_reset();
        run_frames(40, "R8 restart fade");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        t_reset();
        t_mix();
        t_valid();
        t_retarget();
        t_link();
        t_smute();
        t_zero();
        t_rerun();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule